// File: doc/BRIEF.md
# Physical Register Rename Unit

This block renames architectural registers onto a larger set of physical registers for an out-of-order core that buffers speculative results in the physical register file rather than in a separate result buffer. At issue it translates both source register names through a speculative map. It hands the destination a physical register taken from a free list, so that later writers of the same name never collide with earlier readers or writers.

A second map holds the committed state. When an instruction retires, the committed map takes its new physical register. The register that the committed map held before for that name goes back onto the free list. When a speculation turns out wrong, a single flush cycle copies the committed map over the speculative one. The same cycle rebuilds the free list from every physical register that the committed map does not reference. The physical data array and the execution units sit outside this block.

The default configuration has 8 architectural and 32 physical registers. The physical count must be a power of two.

Top module: `prf_rename_unit`

## Requirements
- R1: After reset both maps are the identity (architectural register a maps to physical a). The free list holds physical registers 8 through 31, and they are handed out in ascending order.
- R2: In the same cycle, `iss_phys_a_o` and `iss_phys_b_o` show the speculative mapping of `iss_src_a_i` and `iss_src_b_i`. A destination written in that same cycle is not yet reflected.
- R3: An issue with a destination (`iss_valid_i`=1, `iss_has_dst_i`=1, free list not empty, no flush) takes the oldest free-list entry. That entry is shown on `iss_phys_dst_o` in the same cycle, and the speculative map points the destination at it from the next cycle on.
- R4: An issue with `iss_has_dst_i`=0 takes no free register and changes no mapping, and it never stalls.
- R5: A commit (`cmt_valid_i`=1) sets the committed entry of `cmt_arch_i` to `cmt_phys_i`. It appends the physical register previously held there to the tail of the free list.
- R6: A commit leaves the speculative map unchanged.
- R7: On `flush_i`=1 the speculative map becomes, from the next cycle, equal to the committed map. This includes any commit made in the flush cycle.
- R8: A flush rebuilds the free list so that it holds exactly the physical registers that the committed map does not reference, in ascending order. Its length is therefore 24.
- R9: When the free list is empty and an issue with a destination is presented, `stall_o` is 1. No register is allocated and no mapping changes in that cycle.
- R10: An issue presented in a flush cycle is discarded: it allocates nothing and changes no mapping.
- R11: A commit in a cycle where the free list is empty does not unblock a same-cycle issue. The returned register goes to the next issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid_i | input | 1 | An instruction is presented for renaming |
| iss_src_a_i | input | 3 | First architectural source |
| iss_src_b_i | input | 3 | Second architectural source |
| iss_has_dst_i | input | 1 | The instruction writes a register |
| iss_dst_i | input | 3 | Architectural destination |
| iss_phys_a_o | output | 5 | Physical register of source A |
| iss_phys_b_o | output | 5 | Physical register of source B |
| iss_phys_dst_o | output | 5 | Physical register offered to the destination (free-list head) |
| stall_o | output | 1 | Issue with destination blocked: free list empty |
| cmt_valid_i | input | 1 | An instruction commits |
| cmt_arch_i | input | 3 | Architectural destination of the committing instruction |
| cmt_phys_i | input | 5 | Physical register the committing instruction was given |
| flush_i | input | 1 | Misspeculation: restore committed state |

## Verification
The three translated numbers and `stall_o` are combinational, so they are due in the cycle the issue is presented. Map and free-list updates pass through one register stage and show up one cycle later. The bench drives inputs just after the falling edge and samples all outputs 1 ns later. It advances its own model of the maps and of the free-list order at the rising edge, so each check compares against state that the previous edge settled. Directed phases cover reset, exhausting the free list, a commit that returns a register, and flushes with same-cycle commit and issue. A long pseudo-random phase follows, in which flushes refill the list.

// File: rtl/prf_rename_pkg.sv
// Package: shared defaults and the free-list operation encoding.
// Assumes: nothing beyond standard SystemVerilog.
package prf_rename_pkg;
    localparam int unsigned ARCH_REGS_DEF = 8;
    localparam int unsigned PHYS_REGS_DEF = 32;

    // Per-cycle action on the free-list FIFO when no rebuild is pending.
    typedef enum logic [1:0] {
        FL_HOLD = 2'b00,
        FL_POP  = 2'b01,
        FL_PUSH = 2'b10,
        FL_BOTH = 2'b11
    } fl_op_e;
endpackage

// File: rtl/prf_map_table.sv
// Module: register map table with identity reset, one single-entry write
// port, one whole-table load port and RD_PORTS combinational read ports.
// Assumes: load_en has priority over wr_en; reads return pre-edge contents.
module prf_map_table #(
    parameter int unsigned N_ENTRIES = 8,
    parameter int unsigned VAL_W     = 5,
    parameter int unsigned RD_PORTS  = 2,
    localparam int unsigned IW       = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [VAL_W-1:0] wr_val,
    input  logic             load_en,
    input  logic [VAL_W-1:0] load_vec [N_ENTRIES],
    input  logic [IW-1:0]    rd_idx   [RD_PORTS],
    output logic [VAL_W-1:0] rd_val   [RD_PORTS],
    output logic [VAL_W-1:0] map_vec  [N_ENTRIES]
);
    logic [VAL_W-1:0] map_q [N_ENTRIES];

    // Table update: identity on reset, bulk load, else single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_ENTRIES); i++) begin
                map_q[i] <= VAL_W'(i);
            end
        end else if (load_en) begin
            for (int i = 0; i < int'(N_ENTRIES); i++) begin
                map_q[i] <= load_vec[i];
            end
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_val;
        end
    end

    // Read ports, one per requested lookup.
    for (genvar g = 0; g < int'(RD_PORTS); g++) begin : g_rd
        assign rd_val[g] = map_q[rd_idx[g]];
    end

    assign map_vec = map_q;
endmodule

// File: rtl/prf_free_rebuild.sv
// Module: compacts a free-register bitmask into an ascending list of
// register numbers plus its length, in one combinational pass.
// Assumes: N_REGS is a power of two; unused list slots read as zero.
module prf_free_rebuild #(
    parameter int unsigned N_REGS = 32,
    localparam int unsigned PW    = $clog2(N_REGS),
    localparam int unsigned CW    = $clog2(N_REGS + 1)
) (
    input  logic [N_REGS-1:0] free_mask,
    output logic [PW-1:0]     list_o [N_REGS],
    output logic [CW-1:0]     count_o
);
    // Prefix-count placement: each free register lands at its rank.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int p = 0; p < int'(N_REGS); p++) begin
            list_o[p] = '0;
        end
        for (int p = 0; p < int'(N_REGS); p++) begin
            if (free_mask[p]) begin
                list_o[PW'(cnt)] = PW'(p);
                cnt = cnt + 1;
            end
        end
        count_o = CW'(cnt);
    end
endmodule

// File: rtl/prf_free_fifo.sv
// Module: circular FIFO of free physical register numbers. Reset content
// is ARCH_REGS..N_REGS-1 in order. A rebuild replaces the whole content
// with a supplied list and overrides push and pop.
// Assumes: N_REGS is a power of two; the caller never pops when empty.
module prf_free_fifo #(
    parameter int unsigned N_REGS    = 32,
    parameter int unsigned ARCH_REGS = 8,
    localparam int unsigned PW       = $clog2(N_REGS),
    localparam int unsigned CW       = $clog2(N_REGS + 1),
    localparam int unsigned INIT_CNT = N_REGS - ARCH_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_val,
    input  logic          rebuild,
    input  logic [PW-1:0] rb_list [N_REGS],
    input  logic [CW-1:0] rb_count,
    output logic [PW-1:0] head_val,
    output logic          empty,
    output logic [CW-1:0] count
);
    import prf_rename_pkg::*;

    logic [PW-1:0] slot_q [N_REGS];
    logic [PW-1:0] head_q;
    logic [PW-1:0] tail_q;
    logic [CW-1:0] count_q;
    fl_op_e        op;

    // Encode this cycle's FIFO action.
    assign op = fl_op_e'({push, pop});

    // Storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_REGS); i++) begin
                slot_q[i] <= (i < int'(INIT_CNT)) ? PW'(int'(ARCH_REGS) + i) : '0;
            end
            head_q  <= '0;
            tail_q  <= PW'(INIT_CNT);
            count_q <= CW'(INIT_CNT);
        end else if (rebuild) begin
            for (int i = 0; i < int'(N_REGS); i++) begin
                slot_q[i] <= rb_list[i];
            end
            head_q  <= '0;
            tail_q  <= PW'(rb_count);
            count_q <= rb_count;
        end else begin
            case (op)
                FL_POP: begin
                    head_q  <= head_q + 1'b1;
                    count_q <= count_q - 1'b1;
                end
                FL_PUSH: begin
                    slot_q[tail_q] <= push_val;
                    tail_q  <= tail_q + 1'b1;
                    count_q <= count_q + 1'b1;
                end
                FL_BOTH: begin
                    slot_q[tail_q] <= push_val;
                    tail_q <= tail_q + 1'b1;
                    head_q <= head_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign head_val = slot_q[head_q];
    assign empty    = (count_q == '0);
    assign count    = count_q;
endmodule

// File: rtl/prf_rename_unit.sv
// Module: top of the rename unit. It holds a speculative map (read at
// issue), a committed map (written at commit) and a free-list FIFO. A flush
// copies the committed map into the speculative map and rebuilds the free
// list from the registers the committed map does not reference.
// Assumes: commits arrive in program order and carry the register given at
// issue; PHYS_REGS is a power of two and larger than ARCH_REGS.
module prf_rename_unit #(
    parameter int unsigned ARCH_REGS = prf_rename_pkg::ARCH_REGS_DEF,
    parameter int unsigned PHYS_REGS = prf_rename_pkg::PHYS_REGS_DEF,
    localparam int unsigned AW       = $clog2(ARCH_REGS),
    localparam int unsigned PW       = $clog2(PHYS_REGS),
    localparam int unsigned CW       = $clog2(PHYS_REGS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid_i,
    input  logic [AW-1:0] iss_src_a_i,
    input  logic [AW-1:0] iss_src_b_i,
    input  logic          iss_has_dst_i,
    input  logic [AW-1:0] iss_dst_i,
    output logic [PW-1:0] iss_phys_a_o,
    output logic [PW-1:0] iss_phys_b_o,
    output logic [PW-1:0] iss_phys_dst_o,
    output logic          stall_o,
    input  logic          cmt_valid_i,
    input  logic [AW-1:0] cmt_arch_i,
    input  logic [PW-1:0] cmt_phys_i,
    input  logic          flush_i
);
    logic [PW-1:0]        spec_vec   [ARCH_REGS];
    logic [PW-1:0]        cmt_vec    [ARCH_REGS];
    logic [PW-1:0]        cmt_nxt    [ARCH_REGS];
    logic [AW-1:0]        spec_rd_idx [2];
    logic [PW-1:0]        spec_rd_val [2];
    logic [AW-1:0]        cmt_rd_idx  [1];
    logic [PW-1:0]        cmt_rd_val  [1];
    logic [PHYS_REGS-1:0] free_mask;
    logic [PW-1:0]        rb_list [PHYS_REGS];
    logic [CW-1:0]        rb_count;
    logic [PW-1:0]        fl_head;
    logic                 fl_empty;
    logic [CW-1:0]        fl_count;
    logic                 want_dst;
    logic                 alloc;
    logic                 give_back;

    // Issue qualification: a destination wants a register; alloc if one exists.
    assign want_dst  = iss_valid_i && iss_has_dst_i;
    assign alloc     = want_dst && !fl_empty && !flush_i;
    assign give_back = cmt_valid_i && !flush_i;
    assign stall_o   = want_dst && fl_empty;

    // Speculative map lookups for the two sources.
    assign spec_rd_idx[0] = iss_src_a_i;
    assign spec_rd_idx[1] = iss_src_b_i;
    assign cmt_rd_idx[0]  = cmt_arch_i;

    prf_map_table #(
        .N_ENTRIES (ARCH_REGS),
        .VAL_W     (PW),
        .RD_PORTS  (2)
    ) u_spec_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (alloc),
        .wr_idx   (iss_dst_i),
        .wr_val   (fl_head),
        .load_en  (flush_i),
        .load_vec (cmt_nxt),
        .rd_idx   (spec_rd_idx),
        .rd_val   (spec_rd_val),
        .map_vec  (spec_vec)
    );

    prf_map_table #(
        .N_ENTRIES (ARCH_REGS),
        .VAL_W     (PW),
        .RD_PORTS  (1)
    ) u_cmt_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmt_valid_i),
        .wr_idx   (cmt_arch_i),
        .wr_val   (cmt_phys_i),
        .load_en  (1'b0),
        .load_vec (cmt_nxt),
        .rd_idx   (cmt_rd_idx),
        .rd_val   (cmt_rd_val),
        .map_vec  (cmt_vec)
    );

    // Committed map as it will be after this edge (used by a flush).
    always_comb begin
        for (int a = 0; a < int'(ARCH_REGS); a++) begin
            cmt_nxt[a] = cmt_vec[a];
        end
        if (cmt_valid_i) begin
            cmt_nxt[cmt_arch_i] = cmt_phys_i;
        end
    end

    // Free mask for a rebuild: every register the committed map leaves out.
    always_comb begin
        free_mask = '1;
        for (int a = 0; a < int'(ARCH_REGS); a++) begin
            free_mask[cmt_nxt[a]] = 1'b0;
        end
    end

    prf_free_rebuild #(
        .N_REGS (PHYS_REGS)
    ) u_rebuild (
        .free_mask (free_mask),
        .list_o    (rb_list),
        .count_o   (rb_count)
    );

    prf_free_fifo #(
        .N_REGS    (PHYS_REGS),
        .ARCH_REGS (ARCH_REGS)
    ) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (give_back),
        .push_val (cmt_rd_val[0]),
        .rebuild  (flush_i),
        .rb_list  (rb_list),
        .rb_count (rb_count),
        .head_val (fl_head),
        .empty    (fl_empty),
        .count    (fl_count)
    );

    assign iss_phys_a_o   = spec_rd_val[0];
    assign iss_phys_b_o   = spec_rd_val[1];
    assign iss_phys_dst_o = fl_head;
endmodule

// File: rtl/prf_rename_checker.sv
// Module: property checker for the rename unit, attached with bind.
// Assumes: it is bound to prf_rename_unit and sees its internal maps and count.
module prf_rename_checker #(
    parameter int unsigned ARCH_REGS = 8,
    parameter int unsigned PHYS_REGS = 32,
    localparam int unsigned AW       = $clog2(ARCH_REGS),
    localparam int unsigned PW       = $clog2(PHYS_REGS),
    localparam int unsigned CW       = $clog2(PHYS_REGS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid_i,
    input logic          iss_has_dst_i,
    input logic          cmt_valid_i,
    input logic          flush_i,
    input logic          stall_o,
    input logic [PW-1:0] iss_phys_dst_o,
    input logic [PW-1:0] spec_vec [ARCH_REGS],
    input logic [PW-1:0] cmt_vec  [ARCH_REGS],
    input logic [CW-1:0] fl_count
);
    localparam int unsigned SPARE = PHYS_REGS - ARCH_REGS;

    logic dst_in_spec;
    logic dst_in_cmt;
    logic maps_equal;
    logic takes_reg;

    // Is the offered destination already named by either map?
    always_comb begin
        dst_in_spec = 1'b0;
        dst_in_cmt  = 1'b0;
        maps_equal  = 1'b1;
        for (int a = 0; a < int'(ARCH_REGS); a++) begin
            dst_in_spec = dst_in_spec | (spec_vec[a] == iss_phys_dst_o);
            dst_in_cmt  = dst_in_cmt  | (cmt_vec[a]  == iss_phys_dst_o);
            maps_equal  = maps_equal  & (spec_vec[a] == cmt_vec[a]);
        end
    end

    assign takes_reg = iss_valid_i && iss_has_dst_i && !stall_o && !flush_i;

    assert_fresh_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        takes_reg |-> (!dst_in_spec && !dst_in_cmt));

    assert_stall_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (fl_count == '0));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !cmt_valid_i && !flush_i) |=> $stable(fl_count));

    assert_no_overfill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= CW'(SPARE));

    assert_flush_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> maps_equal);

    assert_flush_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (fl_count == CW'(SPARE)));
endmodule

bind prf_rename_unit prf_rename_checker #(
    .ARCH_REGS (ARCH_REGS),
    .PHYS_REGS (PHYS_REGS)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .iss_valid_i    (iss_valid_i),
    .iss_has_dst_i  (iss_has_dst_i),
    .cmt_valid_i    (cmt_valid_i),
    .flush_i        (flush_i),
    .stall_o        (stall_o),
    .iss_phys_dst_o (iss_phys_dst_o),
    .spec_vec       (spec_vec),
    .cmt_vec        (cmt_vec),
    .fl_count       (fl_count)
);

// File: tb/prf_rename_unit_test.sv
`timescale 1ns/1ps
// Bench: directed phases then a pseudo-random phase against a bench-side
// model of both maps, the free-list order and the in-flight commit queue.
module prf_rename_unit_test;
    localparam int A = 8;
    localparam int P = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid_i = 1'b0;
    logic [2:0] iss_src_a_i = '0;
    logic [2:0] iss_src_b_i = '0;
    logic       iss_has_dst_i = 1'b0;
    logic [2:0] iss_dst_i = '0;
    logic [4:0] iss_phys_a_o;
    logic [4:0] iss_phys_b_o;
    logic [4:0] iss_phys_dst_o;
    logic       stall_o;
    logic       cmt_valid_i = 1'b0;
    logic [2:0] cmt_arch_i = '0;
    logic [4:0] cmt_phys_i = '0;
    logic       flush_i = 1'b0;

    int nchk = 0;
    int nbad = 0;
    int spec_m [A];
    int cmt_m  [A];
    int freeq  [$];
    int inf_a  [$];
    int inf_p  [$];
    int unsigned rs = 32'h1234_5678;

    always #2.5 clk = ~clk;

    prf_rename_unit uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .iss_valid_i    (iss_valid_i),
        .iss_src_a_i    (iss_src_a_i),
        .iss_src_b_i    (iss_src_b_i),
        .iss_has_dst_i  (iss_has_dst_i),
        .iss_dst_i      (iss_dst_i),
        .iss_phys_a_o   (iss_phys_a_o),
        .iss_phys_b_o   (iss_phys_b_o),
        .iss_phys_dst_o (iss_phys_dst_o),
        .stall_o        (stall_o),
        .cmt_valid_i    (cmt_valid_i),
        .cmt_arch_i     (cmt_arch_i),
        .cmt_phys_i     (cmt_phys_i),
        .flush_i        (flush_i)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    // One clock: drive, check combinational outputs, advance the model at the edge.
    task automatic cycle(input string tag, input bit iv, input int sa, input int sb,
                         input bit hd, input int d, input bit cv, input bit fl);
        bit do_cmt;
        bit exp_stall;
        bit fire;
        int ca;
        int cp;
        do_cmt = cv && (inf_a.size() > 0);
        ca = do_cmt ? inf_a[0] : 0;
        cp = do_cmt ? inf_p[0] : 0;
        iss_valid_i   = iv;
        iss_src_a_i   = 3'(sa);
        iss_src_b_i   = 3'(sb);
        iss_has_dst_i = hd;
        iss_dst_i     = 3'(d);
        cmt_valid_i   = do_cmt;
        cmt_arch_i    = 3'(ca);
        cmt_phys_i    = 5'(cp);
        flush_i       = fl;
        #1;
        chk(tag, "phys_a", int'(iss_phys_a_o), spec_m[sa]);
        chk(tag, "phys_b", int'(iss_phys_b_o), spec_m[sb]);
        exp_stall = iv && hd && (freeq.size() == 0);
        chk(tag, "stall", int'(stall_o), int'(exp_stall));
        if (iv && hd && freeq.size() > 0)
            chk(tag, "phys_dst", int'(iss_phys_dst_o), freeq[0]);
        @(posedge clk);
        fire = iv && hd && !fl && (freeq.size() > 0);
        if (fire) begin
            spec_m[d] = freeq.pop_front();
            inf_a.push_back(d);
            inf_p.push_back(spec_m[d]);
        end
        if (do_cmt) begin
            void'(inf_a.pop_front());
            void'(inf_p.pop_front());
            if (!fl) freeq.push_back(cmt_m[ca]);
            cmt_m[ca] = cp;
        end
        if (fl) begin
            bit used [P];
            for (int p = 0; p < P; p++) used[p] = 1'b0;
            for (int a = 0; a < A; a++) begin
                spec_m[a] = cmt_m[a];
                used[cmt_m[a]] = 1'b1;
            end
            freeq.delete();
            for (int p = 0; p < P; p++) if (!used[p]) freeq.push_back(p);
            inf_a.delete();
            inf_p.delete();
        end
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 150000);
        nbad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, -1);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        for (int a = 0; a < A; a++) begin
            spec_m[a] = a;
            cmt_m[a]  = a;
        end
        for (int p = A; p < P; p++) freeq.push_back(p);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: identity map after reset, swept over every source pair.
        for (int a = 0; a < A; a++)
            for (int b = 0; b < A; b++)
                cycle("R1", 1'b0, a, b, 1'b0, 0, 1'b0, 1'b0);
        chk("R1", "free count", freeq.size(), 24);

        // R3 and R2: drain the free list (8..31 ascending), sources follow renames.
        for (int i = 0; i < 24; i++)
            cycle("R3", 1'b1, (i * 3) % A, (i + 5) % A, 1'b1, i % A, 1'b0, 1'b0);
        // R2: source equal to destination in the same cycle sees the old mapping.
        cycle("R9", 1'b1, 2, 2, 1'b1, 2, 1'b0, 1'b0);
        // R4: an issue without destination on an empty list does not stall.
        cycle("R4", 1'b1, 1, 4, 1'b0, 1, 1'b0, 1'b0);
        chk("R4", "stall_o after no-dst issue", int'(stall_o), 0);
        // R11: commit while empty does not unblock the same-cycle issue.
        cycle("R11", 1'b1, 0, 3, 1'b1, 5, 1'b1, 1'b0);
        // R5: next issue receives the register the commit returned (physical 0).
        chk("R5", "returned reg at head", int'(iss_phys_dst_o), 0);
        cycle("R5", 1'b1, 5, 6, 1'b1, 5, 1'b0, 1'b0);
        // R6: commits do not disturb the speculative map.
        for (int i = 0; i < 4; i++)
            cycle("R6", 1'b0, i, i + 4, 1'b0, 0, 1'b1, 1'b0);
        for (int a = 0; a < A; a++)
            cycle("R6", 1'b0, a, (a + 1) % A, 1'b0, 0, 1'b0, 1'b0);
        // R7: flush with a same-cycle commit; maps restored next cycle.
        cycle("R7", 1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b1);
        for (int a = 0; a < A; a++)
            cycle("R7", 1'b0, a, (A - 1) - a, 1'b0, 0, 1'b0, 1'b0);
        // R8: rebuilt free list is handed out in ascending order.
        for (int i = 0; i < 6; i++)
            cycle("R8", 1'b1, i % A, 7, 1'b1, (i + 2) % A, 1'b0, 1'b0);
        // R10: an issue in a flush cycle is dropped.
        cycle("R10", 1'b1, 3, 3, 1'b1, 3, 1'b0, 1'b1);
        cycle("R10", 1'b1, 2, 3, 1'b1, 4, 1'b0, 1'b0);

        // Pseudo-random mix of issue, commit and occasional flush.
        for (int n = 0; n < 6000; n++) begin
            int unsigned r;
            r = rnd();
            cycle("R3", r[0] | r[1], int'(r[6:4]), int'(r[9:7]), r[2] | r[3],
                  int'(r[12:10]), r[13] & (r[14] | r[15]), r[20:16] == 5'd0);
        end

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule